// File: doc/BRIEF.md
# Interrupt-Triggered Transfer Engine

This block moves one data item per trigger on any of several channels, without help from a processor. Each channel holds a source address, a destination address, a down-counter and a configuration byte. A trigger pulse on a channel queues one transfer. The engine reads one item from the source address and writes it to the destination address over a simple request/acknowledge bus. It then steps the address on the memory side by the item size, decrements the channel counter, and pulses that channel's terminal-count line when the counter reaches zero.

The configuration byte sets the transfer size (1, 2 or 4 bytes) and one of six behaviours. The memory side can be the destination or the source, and it steps up or down. A third behaviour keeps both addresses fixed. A fourth moves no data and only bumps the source register by one on each trigger, so the channel counts events. A host loads the registers through a narrow write port. An illegal configuration disables the channel and raises a sticky per-channel error flag.

Top module: `udma_engine`

## Requirements
- R1: The configuration byte holds the operation code in bits [4:2] and the size code in bits [1:0]. Size code 0 moves 1 byte, code 1 moves 2 bytes and code 2 moves 4 bytes. Every bus request carries the channel's size code on `bus_size`.
- R2: Operation codes 0 and 1 read from the unchanged source address and write to the destination address. After each transfer the destination steps up (code 0) or down (code 1) by the item size.
- R3: Operation codes 2 and 3 read from the source address and write to the unchanged destination address. After each transfer the source steps up (code 2) or down (code 3) by the item size.
- R4: Operation code 4 reads from the source address and writes to the destination address, and neither address ever changes.
- R5: Operation code 5 issues no bus request. Each trigger adds exactly one to the source register, and a later transfer shows the new value as its read address.
- R6: Every serviced trigger decrements the channel counter by one. When the counter reaches zero, that channel's `tc_irq` bit is high for exactly one cycle, in the cycle after the transfer ends.
- R7: A configuration byte is illegal when bits [7:5] are not zero, the operation code is above 5, or the size code is 3. Writing an illegal byte sets the channel's `chan_err` bit and disables the channel, and its triggers then start no bus cycle. Writing a legal byte clears the error and enables the channel.
- R8: Only one transfer is in progress at a time. When several channels are pending, the lowest-numbered one is served first.
- R9: With a bus that acknowledges at once, `busy` stays high for 4 cycles on codes 0 to 3, 3 cycles on code 4 and 2 cycles on code 5.
- R10: After reset `busy`, `bus_req`, `tc_irq` and `chan_err` are low, and all channels are disabled, so a trigger does nothing until a legal configuration is written.
- R11: While `bus_req` is high and `bus_ack` is low, the request, its direction and its address are held steady, and each stalled cycle adds one cycle to `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_chan | input | IW | Channel selected for the write |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 counter, 3 configuration |
| cfg_data | input | AW | Write data |
| trig | input | NCH | One-cycle trigger pulse per channel |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | AW | Bus address |
| bus_size | output | 2 | Size code of the current request |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with the acknowledge |
| bus_ack | input | 1 | Acknowledge, completes the request |
| tc_irq | output | NCH | Terminal-count pulse per channel |
| chan_err | output | NCH | Sticky illegal-configuration flag per channel |
| busy | output | 1 | A transfer is in progress |

## Verification
The hardest state to see from the ports is the source register of a channel in counting mode, because that mode never drives the bus. The bench triggers such a channel twice, rewrites only its configuration byte to the fixed-address code, and triggers it again. The read address of that third transfer then shows the accumulated count. Address stepping is checked the same way, by comparing the first and second transfers of every channel, operation code and size combination. Bus stalls are produced by holding off the acknowledge for a known number of cycles.

// File: rtl/udma_pkg.sv
package udma_pkg;

  typedef enum logic [2:0] {
    M_DST_INC = 3'd0,
    M_DST_DEC = 3'd1,
    M_SRC_INC = 3'd2,
    M_SRC_DEC = 3'd3,
    M_FIXED   = 3'd4,
    M_COUNT   = 3'd5
  } xfer_mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_WR, S_UPD, S_FIN, S_CNT
  } eng_state_e;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_MODE = 2'd3;

  // legality of a configuration byte
  function automatic logic cfg_legal(input logic [7:0] v);
    return (v[7:5] == 3'd0) && (v[4:2] <= 3'd5) && (v[1:0] != 2'd3);
  endfunction

  // bytes moved per transfer for a size code
  function automatic logic [2:0] step_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/udma_chan_regs.sv
module udma_chan_regs
  import udma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [1:0]    host_sel,
  input  logic [AW-1:0] host_data,
  input  logic          eng_src_we,
  input  logic [AW-1:0] eng_src_nx,
  input  logic          eng_dst_we,
  input  logic [AW-1:0] eng_dst_nx,
  input  logic          eng_cnt_dec,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt,
  output logic [2:0]    mode,
  output logic [1:0]    size,
  output logic          live,
  output logic          fault,
  output logic          tc_pulse
);

  logic [7:0] cfg_byte;
  assign cfg_byte = host_data[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src      <= '0;
      dst      <= '0;
      cnt      <= '0;
      mode     <= 3'd0;
      size     <= 2'd0;
      live     <= 1'b0;
      fault    <= 1'b0;
      tc_pulse <= 1'b0;
    end else begin
      tc_pulse <= 1'b0;
      if (eng_src_we) src <= eng_src_nx;
      if (eng_dst_we) dst <= eng_dst_nx;
      if (eng_cnt_dec) begin
        cnt      <= cnt - CW'(1);
        tc_pulse <= (cnt == CW'(1));
      end
      // host writes take precedence over engine updates
      if (host_we) begin
        case (host_sel)
          SEL_SRC: src <= host_data;
          SEL_DST: dst <= host_data;
          SEL_CNT: cnt <= host_data[CW-1:0];
          default: begin
            if (cfg_legal(cfg_byte)) begin
              mode  <= cfg_byte[4:2];
              size  <= cfg_byte[1:0];
              live  <= 1'b1;
              fault <= 1'b0;
            end else begin
              live  <= 1'b0;
              fault <= 1'b1;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/udma_arb.sv
module udma_arb #(
  parameter int NCH = 4,
  parameter int IW  = 2
) (
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] grant,
  output logic [IW-1:0]  gidx
);

  always_comb begin
    gidx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) gidx = i[IW-1:0];
    end
    grant = '0;
    if (|req) grant[gidx] = 1'b1;
  end

endmodule

// File: rtl/udma_engine.sv
module udma_engine
  import udma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = 16,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_chan,
  input  logic [1:0]     cfg_sel,
  input  logic [AW-1:0]  cfg_data,
  input  logic [NCH-1:0] trig,
  output logic           bus_req,
  output logic           bus_we,
  output logic [AW-1:0]  bus_addr,
  output logic [1:0]     bus_size,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata,
  input  logic           bus_ack,
  output logic [NCH-1:0] tc_irq,
  output logic [NCH-1:0] chan_err,
  output logic           busy
);

  logic [AW-1:0] src_a [NCH];
  logic [AW-1:0] dst_a [NCH];
  logic [CW-1:0] cnt_a [NCH];
  logic [2:0]    mode_a [NCH];
  logic [1:0]    size_a [NCH];

  logic [NCH-1:0] live_v, fault_v, tcp_v, pend, grant, clr_v;
  logic [NCH-1:0] src_we_v, dst_we_v, cnt_dec_v;
  logic [IW-1:0]  gidx, act;
  eng_state_e     state;
  logic [DW-1:0]  data_q;

  logic [AW-1:0] a_src, a_dst, src_nx, dst_nx, step;
  logic [2:0]    a_mode;
  logic [1:0]    a_size;

  // named internal events
  logic ev_start, ev_count_step, ev_src_upd, ev_dst_upd, ev_fin;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_chan
      udma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (cfg_we && (cfg_chan == IW'(c))),
        .host_sel   (cfg_sel),
        .host_data  (cfg_data),
        .eng_src_we (src_we_v[c]),
        .eng_src_nx (src_nx),
        .eng_dst_we (dst_we_v[c]),
        .eng_dst_nx (dst_nx),
        .eng_cnt_dec(cnt_dec_v[c]),
        .src        (src_a[c]),
        .dst        (dst_a[c]),
        .cnt        (cnt_a[c]),
        .mode       (mode_a[c]),
        .size       (size_a[c]),
        .live       (live_v[c]),
        .fault      (fault_v[c]),
        .tc_pulse   (tcp_v[c])
      );
      assign src_we_v[c]  = ev_src_upd && (act == IW'(c));
      assign dst_we_v[c]  = ev_dst_upd && (act == IW'(c));
      assign cnt_dec_v[c] = ev_fin && (act == IW'(c));
      assign clr_v[c]     = ev_fin && (act == IW'(c));
    end
  endgenerate

  udma_arb #(.NCH(NCH), .IW(IW)) u_arb (
    .req  (pend & live_v),
    .grant(grant),
    .gidx (gidx)
  );

  assign a_src  = src_a[act];
  assign a_dst  = dst_a[act];
  assign a_mode = mode_a[act];
  assign a_size = size_a[act];
  assign step   = {{(AW-3){1'b0}}, step_bytes(a_size)};

  assign ev_start      = (state == S_IDLE) && (|grant);
  assign ev_count_step = (state == S_CNT);
  assign ev_fin        = (state == S_FIN);
  assign ev_src_upd    = ev_count_step ||
                         ((state == S_UPD) && ((a_mode == M_SRC_INC) || (a_mode == M_SRC_DEC)));
  assign ev_dst_upd    = (state == S_UPD) && ((a_mode == M_DST_INC) || (a_mode == M_DST_DEC));

  always_comb begin
    src_nx = a_src;
    dst_nx = a_dst;
    case (a_mode)
      M_DST_INC: dst_nx = a_dst + step;
      M_DST_DEC: dst_nx = a_dst - step;
      M_SRC_INC: src_nx = a_src + step;
      M_SRC_DEC: src_nx = a_src - step;
      M_COUNT:   src_nx = a_src + AW'(1);
      default:   ;
    endcase
  end

  // pending triggers; a new trigger wins over the clear of the same channel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= ((pend & ~clr_v) | trig) & live_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      act    <= '0;
      data_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (ev_start) begin
          act   <= gidx;
          state <= (mode_a[gidx] == M_COUNT) ? S_CNT : S_RD;
        end
        S_RD: if (bus_ack) begin
          data_q <= bus_rdata;
          state  <= S_WR;
        end
        S_WR: if (bus_ack) state <= (a_mode == M_FIXED) ? S_FIN : S_UPD;
        S_UPD:   state <= S_FIN;
        S_CNT:   state <= S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign bus_req   = (state == S_RD) || (state == S_WR);
  assign bus_we    = (state == S_WR);
  assign bus_addr  = (state == S_WR) ? a_dst : a_src;
  assign bus_size  = a_size;
  assign bus_wdata = data_q;
  assign tc_irq    = tcp_v;
  assign chan_err  = fault_v;
  assign busy      = (state != S_IDLE);

endmodule

// File: rtl/udma_engine_chk.sv
module udma_engine_chk #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int IW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_req,
  input logic           bus_ack,
  input logic           bus_we,
  input logic [AW-1:0]  bus_addr,
  input logic [1:0]     bus_size,
  input logic [NCH-1:0] tc_irq,
  input logic [NCH-1:0] chan_err,
  input logic [NCH-1:0] grant,
  input logic [IW-1:0]  gidx,
  input logic [IW-1:0]  act,
  input logic           ev_start,
  input logic           ev_count_step
);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  assert_size_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_size != 2'b11));

  assert_count_nobus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_count_step |-> !bus_req);

  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_start_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (act == $past(gidx)));

  assert_err_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |-> ((grant & chan_err) == '0));

  assert_tc_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_irq != '0) |=> (tc_irq == '0));

  assert_tc_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tc_irq));

endmodule

bind udma_engine udma_engine_chk #(.NCH(NCH), .AW(AW), .IW(IW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_req      (bus_req),
  .bus_ack      (bus_ack),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_size     (bus_size),
  .tc_irq       (tc_irq),
  .chan_err     (chan_err),
  .grant        (grant),
  .gidx         (gidx),
  .act          (act),
  .ev_start     (ev_start),
  .ev_count_step(ev_count_step)
);

// File: tb/udma_engine_bench.sv
`timescale 1ns/1ps
module udma_engine_bench;
  localparam int NCH = 4;
  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int CW  = 16;
  localparam int IW  = 2;
  localparam logic [31:0] PAT = 32'h5A5A_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_chan = '0;
  logic [1:0] cfg_sel = '0;
  logic [AW-1:0] cfg_data = '0;
  logic [NCH-1:0] trig = '0;
  logic bus_req, bus_we, bus_ack, busy;
  logic [AW-1:0] bus_addr;
  logic [1:0] bus_size;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic [NCH-1:0] tc_irq, chan_err;
  logic stall = 1'b0;

  always #4 clk = ~clk;

  assign bus_ack   = bus_req && !stall;
  assign bus_rdata = bus_addr ^ PAT;

  udma_engine #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) u_udma_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .trig(trig), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .tc_irq(tc_irq), .chan_err(chan_err),
    .busy(busy)
  );

  int n_chk = 0, n_fail = 0;
  int rd_n, wr_n, busy_n, stall_n, tc_n;
  logic [AW-1:0] rd_log [16];
  logic [AW-1:0] wr_log [16];
  logic [DW-1:0] wd_log [16];
  logic [1:0]    sz_log [16];
  bit done = 0;

  // bus and event monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (bus_req && bus_ack && !bus_we) begin
      if (rd_n < 16) begin rd_log[rd_n] = bus_addr; sz_log[rd_n] = bus_size; end
      rd_n++;
    end
    if (bus_req && bus_ack && bus_we) begin
      if (wr_n < 16) begin wr_log[wr_n] = bus_addr; wd_log[wr_n] = bus_wdata; end
      wr_n++;
    end
    if (busy) busy_n++;
    if (bus_req && !bus_ack) stall_n++;
    tc_n += $countones(tc_irq);
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic clear_mon();
    rd_n = 0; wr_n = 0; busy_n = 0; stall_n = 0; tc_n = 0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input int ch, input logic [1:0] sel, input logic [AW-1:0] d);
    cfg_we = 1'b1; cfg_chan = IW'(ch); cfg_sel = sel; cfg_data = d;
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic fire(input logic [NCH-1:0] m);
    trig = m;
    cyc(1);
    trig = '0;
  endtask

  function automatic logic [AW-1:0] stp(input int sz);
    return AW'(1) << sz;
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] s, d, s2e, d2e;
    clear_mon();
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R10: reset state
    chk("R10 busy", busy, 0);
    chk("R10 bus_req", bus_req, 0);
    chk("R10 tc_irq", tc_irq, 0);
    chk("R10 chan_err", chan_err, 0);
    clear_mon();
    fire(4'hF);
    cyc(8);
    chk("R10 unconfigured trigger bus", rd_n + wr_n, 0);
    chk("R10 unconfigured trigger busy", busy_n, 0);

    // sweep: every channel, operation code and size
    for (int ch = 0; ch < NCH; ch++) begin
      for (int m = 0; m < 6; m++) begin
        for (int sz = 0; sz < 3; sz++) begin
          s = 32'h0001_0040 + AW'(ch << 12) + AW'(m << 8) + AW'(sz << 4);
          d = 32'h0002_0080 + AW'(ch << 12) + AW'(m << 8) + AW'(sz << 4);
          wr(ch, 2'd0, s);
          wr(ch, 2'd1, d);
          wr(ch, 2'd2, 32'd2);
          wr(ch, 2'd3, AW'((m << 2) | sz));
          // first trigger
          clear_mon();
          fire(NCH'(1) << ch);
          cyc(8);
          chk("R6 no tc at count 1", tc_n, 0);
          if (m < 5) begin
            chk("R2 R3 R4 first read addr", rd_log[0], s);
            chk("R2 R3 R4 first write addr", wr_log[0], d);
            chk("R4 data moved", wd_log[0], s ^ PAT);
            chk("R1 bus size", sz_log[0], sz);
            chk("R9 busy cycles", busy_n, (m < 4) ? 4 : 3);
          end else begin
            chk("R5 no bus activity", rd_n + wr_n, 0);
            chk("R9 counter busy cycles", busy_n, 2);
          end
          // second trigger
          clear_mon();
          fire(NCH'(1) << ch);
          cyc(8);
          chk("R6 tc at zero", tc_n, 1);
          s2e = s; d2e = d;
          case (m)
            0: d2e = d + stp(sz);
            1: d2e = d - stp(sz);
            2: s2e = s + stp(sz);
            3: s2e = s - stp(sz);
            default: ;
          endcase
          if (m == 0 || m == 1) chk("R2 dest stepped", wr_log[0], d2e);
          if (m == 0 || m == 1) chk("R2 source fixed", rd_log[0], s2e);
          if (m == 2 || m == 3) chk("R3 source stepped", rd_log[0], s2e);
          if (m == 2 || m == 3) chk("R3 dest fixed", wr_log[0], d2e);
          if (m == 4) chk("R4 addresses fixed", {rd_log[0], wr_log[0]}, {s, d});
          if (m == 5) begin
            chk("R5 no bus activity", rd_n + wr_n, 0);
            wr(ch, 2'd3, 32'h10);
            clear_mon();
            fire(NCH'(1) << ch);
            cyc(8);
            chk("R5 source counted", rd_log[0], s + 2);
          end
        end
      end
    end

    // R7: illegal configurations
    wr(1, 2'd0, 32'h300); wr(1, 2'd1, 32'h400); wr(1, 2'd2, 32'd5);
    wr(1, 2'd3, 32'h10);
    wr(1, 2'd3, 32'h18);
    chk("R7 op code 6 flags", chan_err, 4'b0010);
    clear_mon();
    fire(4'b0010);
    cyc(8);
    chk("R7 disabled no bus", rd_n + wr_n, 0);
    chk("R7 disabled not busy", busy_n, 0);
    wr(2, 2'd3, 32'h03);
    chk("R7 size 3 flags", chan_err, 4'b0110);
    wr(3, 2'd3, 32'h20);
    chk("R7 upper bits flag", chan_err, 4'b1110);
    wr(1, 2'd3, 32'h10);
    chk("R7 legal write clears", chan_err, 4'b1100);
    clear_mon();
    fire(4'b0010);
    cyc(8);
    chk("R7 re-enabled transfer", rd_log[0], 32'h300);
    for (int ch = 2; ch < NCH; ch++) wr(ch, 2'd3, 32'h12);
    chk("R7 all cleared", chan_err, 0);

    // R8: fixed priority, one at a time
    for (int ch = 0; ch < NCH; ch++) begin
      wr(ch, 2'd0, 32'h9000 + AW'(ch * 16));
      wr(ch, 2'd1, 32'hA000);
      wr(ch, 2'd2, 32'd9);
      wr(ch, 2'd3, 32'h12);
    end
    clear_mon();
    fire(4'b1111);
    cyc(24);
    chk("R8 transfer count", rd_n, 4);
    for (int ch = 0; ch < NCH; ch++)
      chk("R8 service order", rd_log[ch], 32'h9000 + AW'(ch * 16));
    chk("R8 serial busy cycles", busy_n, 12);

    // R11: stalled bus
    wr(0, 2'd0, 32'h500); wr(0, 2'd1, 32'h600); wr(0, 2'd2, 32'd4);
    wr(0, 2'd3, 32'h01);
    stall = 1'b1;
    clear_mon();
    fire(4'b0001);
    cyc(6);
    stall = 1'b0;
    cyc(10);
    chk("R11 stalled cycles", stall_n, 5);
    chk("R11 busy stretched", busy_n, 9);
    chk("R11 read addr", rd_log[0], 32'h500);
    chk("R11 write data", wd_log[0], 32'h500 ^ PAT);

    done = 1;
    summary();
    $finish;
  end

endmodule